// File: doc/BRIEF.md
# Paged Byte-Wide Control Register Bank

This block is the configuration store of a multi-channel transmit datapath. A host reaches it over a byte-wide microprocessor-style bus: a chip select, a read strobe, a write strobe, a 6-bit address, and a data path split into an input byte and an output byte with an output-enable flag. Every stored value is also driven onto wide parallel output ports, where the datapath that uses it reads it.

The lower half of the address space always maps to the same registers. Addresses 0 to 15 hold sixteen mode and control bytes. Address 14 is the status byte, and its two low bits select a page. Addresses 16 to 31 hold eight 16-bit sample words. The upper half of the address space, addresses 32 to 63, is a window. Its contents depend on the selected page:

- Page 0 holds per-channel tuning: frequency, phase and gain.
- Page 1 is a read-only monitor view.
- Pages 2 and 3 hold the two halves of a 32-entry bank of 16-bit filter coefficients.

A coefficient is written one byte at a time. The low byte waits in a holding register. The stored coefficient changes only when the matching high byte arrives, so the coefficient outputs never show a half-written value.

This is a register interface, not a stream. There is no valid/ready handshake and no back-pressure. A write completes in the clock cycle in which the write strobe is first seen high, and read data is combinational from the address.

Top module: `ctl_regbank`

## Requirements
- R1: After reset every stored byte, every sample word, channel value and coefficient, and the holding register are zero. The pending flag is clear and page 0 is selected.
- R2: A write takes place only in the one clock cycle in which `bus_wr` is seen rising while `bus_cs` is high. Holding `bus_wr` high does not repeat the write. A strobe while `bus_cs` is low changes nothing.
- R3: `bus_oe` is high and `bus_dout` carries the addressed byte only while `bus_cs` and `bus_rd` are both high. Otherwise both are zero.
- R4: Addresses 0 to 13 and 15 are read/write bytes. Byte n appears at `cfg_bytes[8n+7:8n]`.
- R5: Addresses 16 to 31 hold eight 16-bit words in the order I0, Q0, I1, Q1, I2, Q2, I3, Q3. Word k takes address 16+2k for its low byte and 17+2k for its high byte, and appears at `iq_words[16k+15:16k]`.
- R6: Status byte (address 14) layout:
  - Bits [1:0] are the read/write page select, also driven on `page_sel`.
  - Bit 7 is the read-only coefficient-pending flag. Writes to it are ignored.
  - Bits [6:2] read as zero.
  - The page changes only through a write to address 14.
- R7: On page 0, channel c owns addresses 32+8c to 39+8c:
  - Offsets 0 to 3 hold the frequency word, low byte first.
  - Offsets 4 and 5 hold the phase word, low byte first.
  - Offset 6 holds the gain.
  - The values appear on `chan_freq`, `chan_phase` and `chan_gain` at slice c.
- R8: On page 0, offset 7 of each channel slot reads zero, and writes to it change nothing.
- R9: On page 1, address 32 reads the holding register and address 33 reads {pending, 2'b00, 5-bit pending index}. All other page-1 addresses read zero, and all page-1 writes are ignored.
- R10: On pages 2 and 3, address a selects coefficient index (page-2)*16 + (a-32)/2. An even address is the low byte and an odd address is the high byte. Reads return the stored coefficient.
- R11: A low-byte coefficient write loads the holding register and the pending index and sets the pending flag. It leaves `coef_words` unchanged.
- R12: A high-byte write while pending for the same index stores {high, held low} into that coefficient and clears the pending flag. A high-byte write with no pending low byte, or for a different index, changes nothing.
- R13: `coef_center` always shows coefficient 31, the center tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, a rising edge writes |
| bus_addr | input | 6 | Register address |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data, zero when not reading |
| bus_oe | output | 1 | High while read data is driven |
| page_sel | output | 2 | Current window page |
| cfg_bytes | output | 128 | Mode/control bytes 0..15 (status byte as read) |
| iq_words | output | 128 | Eight 16-bit sample words |
| chan_freq | output | 128 | Four 32-bit frequency words |
| chan_phase | output | 64 | Four 16-bit phase words |
| chan_gain | output | 32 | Four 8-bit gain bytes |
| coef_words | output | 512 | Thirty-two 16-bit coefficients |
| coef_center | output | 16 | Coefficient 31 |

## Verification
The hardest case to reach from the ports is a coefficient commit. It needs page 2 or 3 selected, then a low-byte write, then a high-byte write to the very same index. Uniform random addresses almost never produce that sequence. The stimulus therefore switches pages often, and after every random low-byte write it issues the matching high-byte write half of the time. Directed sequences add the two rejected cases, a mismatched index and a missing low byte, and observe them through the page-1 monitor and the status flag.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int DW       = 8;
  localparam int AW       = 6;
  localparam int NUM_CFG  = 16;
  localparam int NUM_CH   = 4;
  localparam int NUM_IQ   = 2 * NUM_CH;
  localparam int IQ_W     = 16;
  localparam int FREQ_W   = 32;
  localparam int PH_W     = 16;
  localparam int GAIN_W   = 8;
  localparam int NUM_COEF = 32;
  localparam int CW       = 16;
  localparam int CIDX_W   = $clog2(NUM_COEF);
  localparam int CH_W     = $clog2(NUM_CH);
  localparam logic [3:0] STATUS_IDX = 4'd14;

  typedef enum logic [1:0] {
    PG_CHAN    = 2'd0,
    PG_MON     = 2'd1,
    PG_COEF_LO = 2'd2,
    PG_COEF_HI = 2'd3
  } page_e;
endpackage

// File: rtl/ctl_bus_if.sv
module ctl_bus_if (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  output logic wr_stb,
  output logic rd_en
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr;
  end

  assign wr_stb = cs & wr & ~wr_q;
  assign rd_en  = cs & rd;
endmodule

// File: rtl/ctl_chan_bank.sv
module ctl_chan_bank
  import ctl_regbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W+2:0]          addr,
  input  logic [DW-1:0]            din,
  output logic [DW-1:0]            rd_data,
  output logic [NUM_CH*FREQ_W-1:0] freq_o,
  output logic [NUM_CH*PH_W-1:0]   phase_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o
);
  logic [CH_W-1:0] sel;
  logic [2:0]      off;
  assign sel = addr[CH_W+2:3];
  assign off = addr[2:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [FREQ_W-1:0] freq_q;
    logic [PH_W-1:0]   phase_q;
    logic [GAIN_W-1:0] gain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_q  <= '0;
        phase_q <= '0;
        gain_q  <= '0;
      end else if (wr_en && sel == CH_W'(c)) begin
        case (off)
          3'd0: freq_q[7:0]   <= din;
          3'd1: freq_q[15:8]  <= din;
          3'd2: freq_q[23:16] <= din;
          3'd3: freq_q[31:24] <= din;
          3'd4: phase_q[7:0]  <= din;
          3'd5: phase_q[15:8] <= din;
          3'd6: gain_q        <= din;
          default: ;
        endcase
      end
    end

    assign freq_o[c*FREQ_W +: FREQ_W] = freq_q;
    assign phase_o[c*PH_W +: PH_W]    = phase_q;
    assign gain_o[c*GAIN_W +: GAIN_W] = gain_q;
  end

  logic [FREQ_W-1:0] freq_s;
  logic [PH_W-1:0]   phase_s;
  logic [GAIN_W-1:0] gain_s;

  always_comb begin
    freq_s  = freq_o[sel*FREQ_W +: FREQ_W];
    phase_s = phase_o[sel*PH_W +: PH_W];
    gain_s  = gain_o[sel*GAIN_W +: GAIN_W];
    case (off)
      3'd0: rd_data = freq_s[7:0];
      3'd1: rd_data = freq_s[15:8];
      3'd2: rd_data = freq_s[23:16];
      3'd3: rd_data = freq_s[31:24];
      3'd4: rd_data = phase_s[7:0];
      3'd5: rd_data = phase_s[15:8];
      3'd6: rd_data = gain_s;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctl_coef_bank.sv
module ctl_coef_bank
  import ctl_regbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CIDX_W-1:0]      idx,
  input  logic                   hi_byte,
  input  logic [DW-1:0]          din,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_COEF*CW-1:0] coef_o,
  output logic [DW-1:0]          hold_o,
  output logic [CIDX_W-1:0]      hold_idx_o,
  output logic                   pend_o
);
  logic [CW-1:0]     coef_q [NUM_COEF];
  logic [DW-1:0]     hold_q;
  logic [CIDX_W-1:0] hidx_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= '0;
      hold_q <= '0;
      hidx_q <= '0;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      if (!hi_byte) begin
        hold_q <= din;
        hidx_q <= idx;
        pend_q <= 1'b1;
      end else if (pend_q && hidx_q == idx) begin
        coef_q[idx] <= {din, hold_q};
        pend_q      <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_out
    assign coef_o[k*CW +: CW] = coef_q[k];
  end

  assign rd_data    = hi_byte ? coef_q[idx][CW-1:DW] : coef_q[idx][DW-1:0];
  assign hold_o     = hold_q;
  assign hold_idx_o = hidx_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_cs,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_din,
  output logic [DW-1:0]             bus_dout,
  output logic                      bus_oe,
  output logic [1:0]                page_sel,
  output logic [NUM_CFG*DW-1:0]     cfg_bytes,
  output logic [NUM_IQ*IQ_W-1:0]    iq_words,
  output logic [NUM_CH*FREQ_W-1:0]  chan_freq,
  output logic [NUM_CH*PH_W-1:0]    chan_phase,
  output logic [NUM_CH*GAIN_W-1:0]  chan_gain,
  output logic [NUM_COEF*CW-1:0]    coef_words,
  output logic [CW-1:0]             coef_center
);
  logic wr_stb, rd_en;

  ctl_bus_if u_bus (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .rd(bus_rd), .wr(bus_wr),
    .wr_stb(wr_stb), .rd_en(rd_en)
  );

  logic [DW-1:0]   cfg_q [NUM_CFG];
  logic [IQ_W-1:0] iq_q  [NUM_IQ];
  page_e           page;
  logic            in_low, in_cfg, in_win;

  assign in_low = ~bus_addr[5];
  assign in_cfg = in_low & ~bus_addr[4];
  assign in_win = bus_addr[5];
  assign page   = page_e'(cfg_q[STATUS_IDX][1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
      for (int i = 0; i < NUM_IQ; i++)  iq_q[i]  <= '0;
    end else if (wr_stb && in_low) begin
      if (in_cfg) begin
        if (bus_addr[3:0] == STATUS_IDX) cfg_q[STATUS_IDX] <= {6'b0, bus_din[1:0]};
        else                             cfg_q[bus_addr[3:0]] <= bus_din;
      end else if (bus_addr[0]) begin
        iq_q[bus_addr[3:1]][15:8] <= bus_din;
      end else begin
        iq_q[bus_addr[3:1]][7:0] <= bus_din;
      end
    end
  end

  // window banks
  logic              chan_wr, coef_wr;
  logic [DW-1:0]     chan_rd, coef_rd, hold_byte;
  logic [CIDX_W-1:0] hold_idx;
  logic              coef_pend;

  assign chan_wr = wr_stb & in_win & (page == PG_CHAN);
  assign coef_wr = wr_stb & in_win & page[1];

  ctl_chan_bank u_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(chan_wr), .addr(bus_addr[4:0]),
    .din(bus_din), .rd_data(chan_rd),
    .freq_o(chan_freq), .phase_o(chan_phase), .gain_o(chan_gain)
  );

  ctl_coef_bank u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_wr),
    .idx({page[0], bus_addr[4:1]}), .hi_byte(bus_addr[0]), .din(bus_din),
    .rd_data(coef_rd), .coef_o(coef_words), .hold_o(hold_byte),
    .hold_idx_o(hold_idx), .pend_o(coef_pend)
  );

  // parallel outputs
  for (genvar n = 0; n < NUM_CFG; n++) begin : g_cfg
    if (n == STATUS_IDX) begin : g_stat
      assign cfg_bytes[n*DW +: DW] = {coef_pend, 5'b0, cfg_q[n][1:0]};
    end else begin : g_plain
      assign cfg_bytes[n*DW +: DW] = cfg_q[n];
    end
  end

  for (genvar k = 0; k < NUM_IQ; k++) begin : g_iq
    assign iq_words[k*IQ_W +: IQ_W] = iq_q[k];
  end

  assign page_sel    = page;
  assign coef_center = coef_words[(NUM_COEF-1)*CW +: CW];

  // read path
  logic [DW-1:0] mon_rd, rd_mux;

  always_comb begin
    case (bus_addr[4:0])
      5'd0:    mon_rd = hold_byte;
      5'd1:    mon_rd = {coef_pend, 2'b00, hold_idx};
      default: mon_rd = '0;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    if (in_cfg) begin
      rd_mux = cfg_bytes[bus_addr[3:0]*DW +: DW];
    end else if (in_low) begin
      rd_mux = bus_addr[0] ? iq_q[bus_addr[3:1]][15:8] : iq_q[bus_addr[3:1]][7:0];
    end else begin
      case (page)
        PG_CHAN: rd_mux = chan_rd;
        PG_MON:  rd_mux = mon_rd;
        default: rd_mux = coef_rd;
      endcase
    end
  end

  assign bus_oe   = rd_en;
  assign bus_dout = rd_en ? rd_mux : '0;
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_cs,
  input logic                   bus_rd,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_dout,
  input logic                   bus_oe,
  input logic                   wr_stb,
  input logic [1:0]             page_sel,
  input logic [NUM_CFG*DW-1:0]  cfg_bytes,
  input logic [NUM_COEF*CW-1:0] coef_words,
  input logic                   coef_pend
);
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_rd) |-> (bus_dout == '0 && !bus_oe)); // R3

  AST_NO_STB_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(cfg_bytes) && $stable(coef_words))); // R2

  AST_PAGE_ONLY_BY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_sel) |-> ($past(wr_stb) && $past(bus_addr) == 6'd14)); // R6

  AST_LOW_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && bus_addr[5] && page_sel[1] && !bus_addr[0]) |=> ($stable(coef_words) && coef_pend)); // R11

  AST_PEND_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coef_pend) |-> ($past(wr_stb) && $past(bus_addr[0]))); // R12
endmodule

bind ctl_regbank ctl_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
  .wr_stb(wr_stb), .page_sel(page_sel), .cfg_bytes(cfg_bytes),
  .coef_words(coef_words), .coef_pend(coef_pend)
);

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_din = '0, bus_dout;
  logic bus_oe;
  logic [1:0] page_sel;
  logic [127:0] cfg_bytes, iq_words, chan_freq;
  logic [63:0] chan_phase;
  logic [31:0] chan_gain;
  logic [511:0] coef_words;
  logic [15:0] coef_center;

  always #10 clk = ~clk;

  ctl_regbank uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m_cfg [16];
  logic [15:0] m_iq [8];
  logic [31:0] m_freq [4];
  logic [15:0] m_ph [4];
  logic [7:0]  m_gain [4];
  logic [15:0] m_coef [32];
  logic [7:0]  m_hold;
  logic [4:0]  m_hidx;
  bit          m_pend;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_cfg[i] = '0;
    for (int i = 0; i < 8; i++) m_iq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_freq[i] = '0; m_ph[i] = '0; m_gain[i] = '0; end
    for (int i = 0; i < 32; i++) m_coef[i] = '0;
    m_hold = '0; m_hidx = '0; m_pend = 0;
  endtask

  function automatic logic [1:0] m_page();
    return m_cfg[14][1:0];
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    logic [4:0] idx;
    int ch, off;
    if (a < 16) begin
      if (a == 14) m_cfg[14] = {6'b0, d[1:0]};
      else m_cfg[a[3:0]] = d;
    end else if (a < 32) begin
      if (a[0]) m_iq[a[3:1]][15:8] = d; else m_iq[a[3:1]][7:0] = d;
    end else begin
      case (m_page())
        2'd0: begin
          ch = int'(a[4:3]); off = int'(a[2:0]);
          if (off < 4) m_freq[ch][off*8 +: 8] = d;
          else if (off < 6) m_ph[ch][(off-4)*8 +: 8] = d;
          else if (off == 6) m_gain[ch] = d;
        end
        2'd1: ;
        default: begin
          idx = {m_page()[0], a[4:1]};
          if (!a[0]) begin m_hold = d; m_hidx = idx; m_pend = 1; end
          else if (m_pend && m_hidx == idx) begin m_coef[idx] = {d, m_hold}; m_pend = 0; end
        end
      endcase
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    int ch, off;
    logic [4:0] idx;
    if (a == 14) return {m_pend, 5'b0, m_page()};
    if (a < 16) return m_cfg[a[3:0]];
    if (a < 32) return a[0] ? m_iq[a[3:1]][15:8] : m_iq[a[3:1]][7:0];
    case (m_page())
      2'd0: begin
        ch = int'(a[4:3]); off = int'(a[2:0]);
        if (off < 4) return m_freq[ch][off*8 +: 8];
        if (off < 6) return m_ph[ch][(off-4)*8 +: 8];
        if (off == 6) return m_gain[ch];
        return 8'h00;
      end
      2'd1: begin
        if (a == 32) return m_hold;
        if (a == 33) return {m_pend, 2'b00, m_hidx};
        return 8'h00;
      end
      default: begin
        idx = {m_page()[0], a[4:1]};
        return a[0] ? m_coef[idx][15:8] : m_coef[idx][7:0];
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [127:0] e_cfg, e_iq, e_fr;
    logic [63:0] e_ph;
    logic [31:0] e_g;
    logic [511:0] e_c;
    for (int i = 0; i < 16; i++) e_cfg[i*8 +: 8] = (i == 14) ? {m_pend, 5'b0, m_page()} : m_cfg[i];
    for (int i = 0; i < 8; i++) e_iq[i*16 +: 16] = m_iq[i];
    for (int i = 0; i < 4; i++) begin
      e_fr[i*32 +: 32] = m_freq[i]; e_ph[i*16 +: 16] = m_ph[i]; e_g[i*8 +: 8] = m_gain[i];
    end
    for (int i = 0; i < 32; i++) e_c[i*16 +: 16] = m_coef[i];
    check({req, " cfg_bytes"}, 512'(cfg_bytes), 512'(e_cfg));
    check({req, " iq_words"}, 512'(iq_words), 512'(e_iq));
    check({req, " chan"}, 512'({chan_freq, chan_phase, chan_gain}), 512'({e_fr, e_ph, e_g}));
    check({req, " coef_words"}, coef_words, e_c);
    check({req, " coef_center R13"}, 512'(coef_center), 512'(m_coef[31]));
    check({req, " page_sel"}, 512'(page_sel), 512'(m_page()));
  endtask

  task automatic wr_byte(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_din = d;
    @(negedge clk);
    bus_wr = 0; bus_cs = 0;
    model_write(a, d);
  endtask

  task automatic rd_check(input logic [5:0] a, input string req);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    #2;
    check({req, " read"}, 512'(bus_dout), 512'(exp_read(a)));
    check({req, " oe"}, 512'(bus_oe), 512'(1));
    bus_cs = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] a;
    logic [7:0] d;
    void'($urandom(32'hC0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_outputs("R1");
    rd_check(6'd14, "R1 status");

    // R3: read idle with rd but no cs
    bus_rd = 1; bus_addr = 6'd14; #2;
    check("R3 dout idle", 512'(bus_dout), 0);
    check("R3 oe idle", 512'(bus_oe), 0);
    bus_rd = 0;

    // R2: strobe without chip select
    @(negedge clk); bus_cs = 0; bus_wr = 1; bus_addr = 6'd0; bus_din = 8'h55;
    @(negedge clk); bus_wr = 0;
    rd_check(6'd0, "R2 no cs");

    // R2: held write strobe writes once
    @(negedge clk); bus_cs = 1; bus_wr = 1; bus_addr = 6'd1; bus_din = 8'hA1;
    @(negedge clk); bus_din = 8'h5E;
    @(negedge clk); bus_wr = 0; bus_cs = 0;
    model_write(6'd1, 8'hA1);
    rd_check(6'd1, "R2 held");

    // R4, R5
    wr_byte(6'd15, 8'h3C); wr_byte(6'd17, 8'hBE); wr_byte(6'd16, 8'hEF);
    wr_byte(6'd31, 8'h12);
    rd_check(6'd15, "R4"); rd_check(6'd17, "R5"); rd_check(6'd31, "R5");
    check_outputs("R4 R5");

    // R6: status read-only/zero bits
    wr_byte(6'd14, 8'hFC);
    rd_check(6'd14, "R6");

    // R7, R8: page 0
    wr_byte(6'd40, 8'h11); wr_byte(6'd43, 8'h44); wr_byte(6'd45, 8'h9A);
    wr_byte(6'd62, 8'h77); wr_byte(6'd39, 8'hFF);
    rd_check(6'd43, "R7"); rd_check(6'd62, "R7"); rd_check(6'd39, "R8");
    check_outputs("R7 R8");

    // R11, R12: coefficient sequence on page 2
    wr_byte(6'd14, 8'h02);
    wr_byte(6'd33, 8'h99);                 // high with nothing pending
    check_outputs("R12 no pending");
    wr_byte(6'd32, 8'h34);                 // low idx 0
    check_outputs("R11 low held");
    rd_check(6'd14, "R6 pend flag");
    wr_byte(6'd35, 8'h88);                 // high idx 1 mismatch
    check_outputs("R12 mismatch");
    wr_byte(6'd33, 8'h12);                 // commit idx 0
    check_outputs("R12 commit");
    rd_check(6'd32, "R10"); rd_check(6'd33, "R10");

    // R13 center tap on page 3
    wr_byte(6'd14, 8'h03);
    wr_byte(6'd62, 8'hCD); wr_byte(6'd63, 8'hAB);
    check_outputs("R13");

    // R9: page 1 monitor, writes ignored
    wr_byte(6'd60, 8'h5A);                 // pending low idx 30
    wr_byte(6'd14, 8'h01);
    wr_byte(6'd32, 8'hEE); wr_byte(6'd40, 8'hEE);
    rd_check(6'd32, "R9"); rd_check(6'd33, "R9"); rd_check(6'd40, "R9");
    check_outputs("R9");

    // random phase
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 6 == 0) a = 6'd14;
      else a = 6'($urandom);
      d = 8'($urandom);
      wr_byte(a, d);
      if (a >= 32 && m_page()[1] && !a[0] && ($urandom % 2 == 0))
        wr_byte(a | 6'd1, 8'($urandom));
      if (it % 4 == 0) rd_check(6'($urandom), "R10 random");
    end
    check_outputs("R12 random");

    // full sweep of every page
    for (int p = 0; p < 4; p++) begin
      wr_byte(6'd14, 8'(p));
      for (int k = 0; k < 64; k++) rd_check(6'(k), "R7 R9 R10 sweep");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule